// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

The block counts ticks from a selectable source and sends each tick through a power-of-two prescaler. If software does not restart it in time, the count wraps. The wrap raises a reset request. If the system is running, the request is a full chip reset. If the system is halted, the request is a warm reset, which clears only the program counter and the stack pointer.

A static mode input sets how software restarts the count:

- **Single-clear mode:** one clear strobe restarts it.
- **Paired-clear mode:** two different clear strobes must both arrive, in either order, before the count restarts.

The block also keeps two status flags for the core. The time-out flag records that the watchdog fired. The power-down flag records that a halt was entered. Software reads the pair to tell the reset causes apart.

Two active-low asynchronous resets are provided. The reset pin restarts the watchdog and leaves the flags as they are. The power-on reset also clears both flags.

Top module: `wdog_pair`

## Requirements
- R1: The 3-bit `presc_sel_i` code k sets the prescale ratio to 2^k, so codes 0 to 7 give ratios 1 to 128. After a restart at edge c, the wrap falls on edge c + 2^k * 2^CNT_W, counted in source ticks.
- R2: `src_sel_i`=0 counts every clock cycle. `src_sel_i`=1 counts only the cycles in which `slow_tick_i` is 1.
- R3: A wrap while not halted drives `chip_rst_o` high for exactly the one cycle after the wrapping edge. At that edge it sets `to_o` to 1 and leaves `pdf_o` unchanged.
- R4: A wrap while halted drives `warm_rst_o` high for exactly one cycle instead of `chip_rst_o`. It sets `to_o` to 1, keeps `pdf_o` at 1 and ends the halted state.
- R5: `halt_i` restarts the count and the prescaler, enters the halted state, sets `pdf_o` to 1 and clears `to_o`.
- R6: With `pair_mode_i`=0, each `clr_i` restarts the count and clears `pdf_o`. `clr1_i` and `clr2_i` have no effect in this mode.
- R7: With `pair_mode_i`=1, the count restarts only once both `clr1_i` and `clr2_i` have been seen. They may arrive in either order or in the same cycle, and repeating one half does nothing. `clr_i` has no effect in this mode.
- R8: A half seen alone is remembered only until the next restart, wrap, halt or reset. After any of these, a lone opposite half does not restart the count.
- R9: `rst_ni` low restarts the count, drops the remembered halves and leaves the halted state. It does not change `to_o` or `pdf_o`, so `{to_o,pdf_o}` reads 01 after a reset-pin wake from halt. `por_ni` low resets everything and forces `{to_o,pdf_o}` to 00.
- R10: A clear or halt in the same cycle as a wrap restarts the count, and no reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Reset pin, active low, asynchronous; the flags are kept |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| src_sel_i | input | 1 | Source select: 0 counts every cycle, 1 counts slow ticks |
| slow_tick_i | input | 1 | Enable from the slow watchdog oscillator, synchronous to clk_i |
| pair_mode_i | input | 1 | Static option: 0 single clear, 1 paired clear |
| presc_sel_i | input | 3 | Prescale code; the ratio is 2^code |
| clr_i | input | 1 | Single clear strobe |
| clr1_i | input | 1 | First half of the paired clear |
| clr2_i | input | 1 | Second half of the paired clear |
| halt_i | input | 1 | Halt command strobe |
| chip_rst_o | output | 1 | One-cycle full chip reset request |
| warm_rst_o | output | 1 | One-cycle warm reset request |
| to_o | output | 1 | Time-out flag |
| pdf_o | output | 1 | Power-down flag |

## Verification
The bench times each restart and predicts the exact edge of the next reset pulse. Any shift in the wrap point shows up as a pulse in the wrong cycle or as an unexpected pulse. This covers a prescaler that divides off by one, a clear that fails to restart, and a clear that lands on the wrap edge but still lets the pulse through.

In paired mode, the bench sends one half twice, sends the single clear, and sends a lone half just after a wrap or a reset. A design that treats one half as enough, or keeps a half across a wrap or reset, would restart too early and miss the expected pulse.

The bench also follows the flag pair through a halt, a warm wake and a reset-pin wake. A design that lets the reset pin clear the flags would read 00 where 01 is expected. A design that gives a chip reset while halted would show the wrong pulse kind.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W = 3;

  typedef enum logic {
    SRC_SYS  = 1'b0,
    SRC_SLOW = 1'b1
  } src_e;

  typedef enum logic {
    CLR_SINGLE = 1'b0,
    CLR_PAIR   = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_tick_i,
  input  logic             sync_clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  // low sel bits of the divider must all be set for a divided tick
  for (genvar i = 0; i < PW; i++) begin : g_mask
    assign mask[i] = (int'(sel_i) > i);
  end

  assign tick_o = src_tick_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (sync_clr_i) cnt_q <= '0;
    else if (src_tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic tick_i,
  output logic wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // restart beats the wrap
  assign wrap_o = tick_i & (&cnt_q) & ~sync_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (sync_clr_i) cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_clr_ctrl.sv
module wdog_clr_ctrl
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pair_mode_i,
  input  logic clr_i,
  input  logic clr1_i,
  input  logic clr2_i,
  input  logic drop_i,
  output logic done_o
);
  clr_mode_e mode;
  logic arm1_q, arm2_q;
  logic seen1, seen2;

  assign mode  = clr_mode_e'(pair_mode_i);
  assign seen1 = arm1_q | clr1_i;
  assign seen2 = arm2_q | clr2_i;

  always_comb begin
    unique case (mode)
      CLR_PAIR: done_o = seen1 & seen2;
      default:  done_o = clr_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm1_q <= 1'b0;
      arm2_q <= 1'b0;
    end else if (done_o || drop_i || mode != CLR_PAIR) begin
      arm1_q <= 1'b0;
      arm2_q <= 1'b0;
    end else begin
      arm1_q <= seen1;
      arm2_q <= seen2;
    end
  end
endmodule

// File: rtl/wdog_pair.sv
module wdog_pair
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             src_sel_i,
  input  logic             slow_tick_i,
  input  logic             pair_mode_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             clr_i,
  input  logic             clr1_i,
  input  logic             clr2_i,
  input  logic             halt_i,
  output logic             chip_rst_o,
  output logic             warm_rst_o,
  output logic             to_o,
  output logic             pdf_o
);
  logic any_rst_n;
  logic src_tick, presc_tick;
  logic clr_done, restart, ovf;
  logic halted_q;

  assign any_rst_n = rst_ni & por_ni;
  assign src_tick  = (src_e'(src_sel_i) == SRC_SLOW) ? slow_tick_i : 1'b1;
  assign restart   = clr_done | halt_i;

  wdog_clr_ctrl u_clr (
    .clk_i       (clk_i),
    .rst_ni      (any_rst_n),
    .pair_mode_i (pair_mode_i),
    .clr_i       (clr_i),
    .clr1_i      (clr1_i),
    .clr2_i      (clr2_i),
    .drop_i      (halt_i | ovf),
    .done_o      (clr_done)
  );

  wdog_presc #(.SEL_W(SEL_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (any_rst_n),
    .src_tick_i (src_tick),
    .sync_clr_i (restart),
    .sel_i      (presc_sel_i),
    .tick_o     (presc_tick)
  );

  wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (any_rst_n),
    .sync_clr_i (restart),
    .tick_i     (presc_tick),
    .wrap_o     (ovf)
  );

  always_ff @(posedge clk_i or negedge any_rst_n) begin
    if (!any_rst_n) begin
      halted_q   <= 1'b0;
      chip_rst_o <= 1'b0;
      warm_rst_o <= 1'b0;
    end else begin
      chip_rst_o <= ovf & ~halted_q;
      warm_rst_o <= ovf & halted_q;
      if (halt_i)   halted_q <= 1'b1;
      else if (ovf) halted_q <= 1'b0;
    end
  end

  // flags survive the reset pin, only power-on clears them
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b0;
    end else if (halt_i) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b1;
    end else begin
      if (ovf)      to_o  <= 1'b1;
      if (clr_done) pdf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_pair_chk.sv
module wdog_pair_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic pair_mode_i,
  input logic clr_i,
  input logic halt_i,
  input logic chip_rst_o,
  input logic warm_rst_o,
  input logic to_o,
  input logic pdf_o
);
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(chip_rst_o && warm_rst_o)); // R4

  AST_CHIP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    chip_rst_o |=> !chip_rst_o); // R3

  AST_WARM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    warm_rst_o |=> !warm_rst_o); // R4

  AST_TO_ON_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (chip_rst_o || warm_rst_o) |-> to_o); // R3

  AST_HALT_FLAGS: assert property (@(posedge clk_i) disable iff (!por_ni)
    halt_i |=> (pdf_o && !to_o)); // R5

  AST_HALT_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    halt_i |=> (!chip_rst_o && !warm_rst_o)); // R10

  AST_SINGLE_CLR: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!pair_mode_i && clr_i && !halt_i) |=> !pdf_o); // R6
endmodule

bind wdog_pair wdog_pair_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .pair_mode_i (pair_mode_i),
  .clr_i       (clr_i),
  .halt_i      (halt_i),
  .chip_rst_o  (chip_rst_o),
  .warm_rst_o  (warm_rst_o),
  .to_o        (to_o),
  .pdf_o       (pdf_o)
);

// File: tb/wdog_pair_bench.sv
`timescale 1ns/1ps
module wdog_pair_bench;
  localparam int CNT_W = 4;
  localparam int SPAN  = 1 << CNT_W;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic       src_sel_i = 1'b0, slow_tick_i = 1'b0, pair_mode_i = 1'b0;
  logic [2:0] presc_sel_i = 3'd0;
  logic       clr_i = 1'b0, clr1_i = 1'b0, clr2_i = 1'b0, halt_i = 1'b0;
  logic       chip_rst_o, warm_rst_o, to_o, pdf_o;

  always #2.5 clk_i = ~clk_i;

  wdog_pair #(.CNT_W(CNT_W)) u_wdog_pair (.*);

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct { int at; bit warm; string req; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0, rc = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every pulse must match the head of the queue
  always @(negedge clk_i) begin
    if (!finished && (chip_rst_o || warm_rst_o)) begin
      if (q.size() == 0) check(1'b0, "R3", "unexpected pulse cycle", cyc, -1);
      else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.at, e.req, "pulse cycle", cyc, e.at);
        check(warm_rst_o == e.warm && chip_rst_o != e.warm, e.req, "pulse kind warm",
              int'(warm_rst_o), int'(e.warm));
      end
    end
  end

  task automatic nclk(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  // driver: strobe for one cycle; rc = edge where it is sampled
  task automatic pulse(bit c, bit c1, bit c2, bit h);
    rc = cyc + 1;
    clr_i = c; clr1_i = c1; clr2_i = c2; halt_i = h;
    nclk(1);
    clr_i = 0; clr1_i = 0; clr2_i = 0; halt_i = 0;
  endtask

  task automatic expect_at(int at, bit warm, string req);
    q.push_back('{at, warm, req});
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R3", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int rc0, rs;
    nclk(3);
    check({chip_rst_o, warm_rst_o, to_o, pdf_o} == 4'b0, "R9", "reset outputs",
          {chip_rst_o, warm_rst_o, to_o, pdf_o}, 0);
    por_ni = 1; rst_ni = 1; rc = cyc;
    expect_at(rc + SPAN, 0, "R3");
    wait_to(rc + SPAN + 1);
    check(to_o == 1, "R3", "to after chip ovf", to_o, 1);
    check(pdf_o == 0, "R3", "pdf unchanged", pdf_o, 0);

    // R1 ratios
    for (int k = 1; k <= 7; k += 3) begin
      presc_sel_i = 3'(k);
      pulse(1, 0, 0, 0);
      expect_at(rc + (1 << k) * SPAN, 0, "R1");
      wait_to(rc + (1 << k) * SPAN + 1);
    end
    presc_sel_i = 3'd0;

    // R6 restart postpones the wrap
    pulse(1, 0, 0, 0); nclk(9); pulse(1, 0, 0, 0);
    expect_at(rc + SPAN, 0, "R6");
    wait_to(rc + SPAN + 1);
    // R6 halves ignored in single mode
    pulse(1, 0, 0, 0); rc0 = rc; nclk(4); pulse(0, 1, 1, 0);
    expect_at(rc0 + SPAN, 0, "R6");
    wait_to(rc0 + SPAN + 1);

    // R5 halt, R4 warm wake, R3 pdf unchanged afterwards
    pulse(0, 0, 0, 1);
    check(pdf_o == 1 && to_o == 0, "R5", "flags after halt", {to_o, pdf_o}, 1);
    expect_at(rc + SPAN, 1, "R4");
    expect_at(rc + 2 * SPAN, 0, "R3");
    wait_to(rc + SPAN + 1);
    check(to_o == 1 && pdf_o == 1, "R4", "flags after warm wake", {to_o, pdf_o}, 3);
    wait_to(rc + 2 * SPAN + 1);
    check(to_o == 1 && pdf_o == 1, "R3", "flags after chip ovf", {to_o, pdf_o}, 3);
    pulse(1, 0, 0, 0);
    check(pdf_o == 0, "R6", "pdf cleared by clr", pdf_o, 0);

    // R7 paired clear
    pair_mode_i = 1;
    pulse(0, 1, 1, 0); rc0 = rc;
    nclk(3); pulse(0, 1, 0, 0); nclk(2); pulse(0, 1, 0, 0); nclk(1); pulse(1, 0, 0, 0);
    expect_at(rc0 + SPAN, 0, "R7");
    wait_to(rc0 + SPAN + 1);
    // R8 halves dropped at wrap
    pulse(0, 0, 1, 0);
    expect_at(rc0 + 2 * SPAN, 0, "R8");
    wait_to(rc0 + 2 * SPAN + 1);
    pulse(0, 0, 1, 0); nclk(3); pulse(0, 1, 0, 0);
    expect_at(rc + SPAN, 0, "R7");
    wait_to(rc + SPAN + 1);

    // R10 clear on the wrap edge
    pulse(0, 1, 1, 0); rc0 = rc;
    wait_to(rc0 + SPAN - 1);
    pulse(0, 1, 1, 0);
    check(rc == rc0 + SPAN, "R10", "clr lands on wrap edge", rc, rc0 + SPAN);
    expect_at(rc + SPAN, 0, "R10");
    wait_to(rc + SPAN + 1);
    pair_mode_i = 0;
    pulse(1, 0, 0, 0); rc0 = rc;
    wait_to(rc0 + SPAN - 1);
    pulse(0, 0, 0, 1);
    expect_at(rc + SPAN, 1, "R10");
    wait_to(rc + SPAN + 1);

    // R9 reset-pin wake from halt, R8 halves dropped by reset
    pair_mode_i = 1;
    pulse(0, 0, 0, 1);
    pulse(0, 1, 0, 0);
    rst_ni = 0; nclk(2);
    check(to_o == 0 && pdf_o == 1, "R9", "flags after pin wake", {to_o, pdf_o}, 1);
    check(!chip_rst_o && !warm_rst_o, "R9", "no pulse in reset", chip_rst_o, 0);
    rst_ni = 1; rs = cyc;
    nclk(3); pulse(0, 0, 1, 0);
    expect_at(rs + SPAN, 0, "R9");
    wait_to(rs + SPAN + 1);
    check(to_o == 1 && pdf_o == 1, "R9", "flags before pin reset", {to_o, pdf_o}, 3);
    rst_ni = 0; nclk(2); rst_ni = 1;
    pair_mode_i = 0;
    pulse(1, 0, 0, 0);
    check(to_o == 1 && pdf_o == 0, "R9", "to kept across pin reset", {to_o, pdf_o}, 2);

    // R2 slow source
    src_sel_i = 1;
    pulse(1, 0, 0, 0);
    nclk(SPAN + 4);
    for (int i = 0; i < SPAN; i++) begin
      slow_tick_i = 1;
      if (i == SPAN - 1) expect_at(cyc + 1, 0, "R2");
      nclk(1);
      slow_tick_i = 0;
      nclk(2);
    end
    nclk(2);
    src_sel_i = 0;

    // R9 power-on clears flags
    por_ni = 0; nclk(2);
    check(to_o == 0 && pdf_o == 0, "R9", "flags after por", {to_o, pdf_o}, 0);
    check(q.size() == 0, "R3", "expected pulses left", q.size(), 0);
    summary();
  end
endmodule